// File: doc/BRIEF.md
# Vertical chroma upsampler, 4:2:0 to 4:2:2

This block doubles the vertical resolution of one planar chroma component. Every chroma line that enters is held in a small ring of line stores. Once enough lines are present, the block emits two full-width lines for it. The first is the anchor line and the second is the interpolated line. Each output sample is a 4-tap vertical filter over the same column of four neighbouring lines. The coefficients are signed fixed-point values, and each output line has its own set of four.

There are four coefficient sets: an anchor set and an interpolation set for each field identity. The field flag sampled with the first sample of a frame picks which pair the frame uses. For progressive material, software loads identical sets for both fields. A mode field switches the block to pass-through for 4:2:2 sources. In that mode each input line comes out once, unchanged, on the same schedule.

Configuration is written into shadow words at any time. The whole shadow is copied into the working copy when a frame starts. The input stalls through `in_ready_o` while output lines are emitted.

Top module: `chroma_vup`

## Requirements
- R1: After reset, `out_valid_o` is low and `in_ready_o` is high.
- R2: Coefficients are 14-bit two's complement Q4.10 values. Bits 13..10 hold the sign and integer part, and bits 9..0 hold the fraction. Each configuration word `w` holds one coefficient in bits [31:18] and one in bits [15:2]. Set `s = 2*fid + interp` uses word `2s` for taps C0 (bits [31:18]) and C1 (bits [15:2]), and word `2s+1` for C2 and C3. The mode is bits [17:16] of word 0.
- R3: A filtered sample is computed in four steps. First form `sum = C0*p(k-1) + C1*p(k) + C2*p(k+1) + C3*p(k+2)` at full precision. Then add 512. Then shift arithmetically right by 10. Finally clamp the result to 0..255.
- R4: Line numbers below 0 are replaced by line 0, and line numbers above NUM_LINES-1 are replaced by line NUM_LINES-1.
- R5: In filter mode (mode value other than 1), output line k is made of LINE_W anchor samples with `out_interp_o`=0, followed by LINE_W interpolated samples with `out_interp_o`=1. `out_sol_o` marks the first sample of each output line. Line k is emitted once input line k+2 is complete. After the last input line, lines NUM_LINES-3, NUM_LINES-2 and NUM_LINES-1 are emitted in that order. No output appears before three full input lines have been taken.
- R6: `in_fid_i`, taken with the sample that carries `in_sof_i`, selects the field-0 sets (value 0) or the field-1 sets (value 1) for the whole frame.
- R7: With mode value 1, each input line is emitted once, unchanged, with `out_interp_o`=0, on the same schedule as R5. The coefficients have no effect.
- R8: Configuration writes take effect only at the next accepted sample with `in_sof_i` set. A write made mid-frame changes nothing in that frame.
- R9: `in_ready_o` is low from the cycle after a line's last sample is accepted until that line's emission ends. Samples of one output line appear on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_addr_i | input | 3 | Configuration word index 0..7 |
| cfg_wdata_i | input | 32 | Configuration word data |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block accepts input samples |
| in_data_i | input | PIX_W | Input chroma sample |
| in_sof_i | input | 1 | Sample is the first of a frame |
| in_fid_i | input | 1 | Field identity, taken with the frame-start sample |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | PIX_W | Output chroma sample |
| out_sol_o | output | 1 | First sample of an output line |
| out_interp_o | output | 1 | Sample belongs to an interpolated line |

## Verification
A smooth ramp under the progressive coefficient sets checks ordinary rounding and the replication of edge lines at the top and bottom. The same irregular picture is filtered twice, once flagged as field 1 and once as field 0, with different sets loaded per field. The two outputs can only match the model if the field flag actually selects the sets. Lines alternating between 0 and 255, under a gain of 3 and a gain of -2, drive both clamp limits. A pass-through frame carries a mid-frame write that switches to filter mode, and the frame after it must show the new setting. Together these tell deferred configuration apart from immediate configuration, and the one-line pass-through schedule apart from the two-line filter schedule.

// File: rtl/chroma_vup_pkg.sv
package chroma_vup_pkg;
  localparam int unsigned TAPS    = 4;
  localparam int unsigned NSLOT   = 4;
  localparam int unsigned SLOT_W  = 2;
  localparam int unsigned COEF_W  = 14;
  localparam int unsigned FRAC_W  = 10;
  localparam int unsigned CFG_N   = 8;
  localparam logic [1:0]  MODE_PASS = 2'd1;

  typedef enum logic {ST_IN, ST_EMIT} st_e;
endpackage

// File: rtl/chroma_vup_cfg.sv
module chroma_vup_cfg
  import chroma_vup_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [2:0]                    addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic                          load_i,
  input  logic                          fid_i,
  input  logic                          pass_i,
  output logic [TAPS-1:0][COEF_W-1:0]   coef_o,
  output logic                          byp_o
);
  logic [31:0] shd_q [CFG_N];
  logic [31:0] act_q [CFG_N];
  logic        fid_q;
  logic [31:0] w_lo, w_hi;
  logic        unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_N; i++) begin
        shd_q[i] <= '0;
        act_q[i] <= '0;
      end
      fid_q <= 1'b0;
    end else begin
      if (we_i) shd_q[addr_i] <= wdata_i;
      if (load_i) begin
        for (int i = 0; i < CFG_N; i++) act_q[i] <= shd_q[i];
        fid_q <= fid_i;
      end
    end
  end

  assign w_lo = act_q[{fid_q, pass_i, 1'b0}];
  assign w_hi = act_q[{fid_q, pass_i, 1'b1}];
  assign coef_o[0] = w_lo[31 -: COEF_W];
  assign coef_o[1] = w_lo[15 -: COEF_W];
  assign coef_o[2] = w_hi[31 -: COEF_W];
  assign coef_o[3] = w_hi[15 -: COEF_W];
  assign byp_o = (act_q[0][17:16] == MODE_PASS);
  assign unused_bits = ^{w_lo[17:16], w_lo[1:0], w_hi[17:16], w_hi[1:0]};
endmodule

// File: rtl/chroma_vup_lbuf.sv
module chroma_vup_lbuf
  import chroma_vup_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LINE_W = 8,
  localparam int unsigned XW    = $clog2(LINE_W)
) (
  input  logic                           clk_i,
  input  logic                           we_i,
  input  logic [SLOT_W-1:0]              wslot_i,
  input  logic [XW-1:0]                  wx_i,
  input  logic [PIX_W-1:0]               wdata_i,
  input  logic [TAPS-1:0][SLOT_W-1:0]    rslot_i,
  input  logic [XW-1:0]                  rx_i,
  output logic [TAPS-1:0][PIX_W-1:0]     rdata_o
);
  logic [PIX_W-1:0] mem_q [NSLOT][LINE_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wslot_i][wx_i] <= wdata_i;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_rd
    assign rdata_o[t] = mem_q[rslot_i[t]][rx_i];
  end
endmodule

// File: rtl/chroma_vup_fir.sv
module chroma_vup_fir
  import chroma_vup_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic [TAPS-1:0][COEF_W-1:0] coef_i,
  input  logic [TAPS-1:0][PIX_W-1:0]  pix_i,
  output logic [PIX_W-1:0]            pix_o
);
  localparam int unsigned SUM_W = COEF_W + PIX_W + 3;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0] acc, shf;

  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    logic signed [SUM_W-1:0] c_ext, p_ext;
    assign c_ext = {{(SUM_W-COEF_W){coef_i[t][COEF_W-1]}}, coef_i[t]};
    assign p_ext = {{(SUM_W-PIX_W){1'b0}}, pix_i[t]};
    assign prod[t] = c_ext * p_ext;
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
    shf = (acc + HALF) >>> FRAC_W;
    if (shf < 0)          pix_o = '0;
    else if (shf > MAXV)  pix_o = MAXV[PIX_W-1:0];
    else                  pix_o = shf[PIX_W-1:0];
  end
endmodule

// File: rtl/chroma_vup.sv
module chroma_vup
  import chroma_vup_pkg::*;
#(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned LINE_W    = 8,
  parameter int unsigned NUM_LINES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_data_i,
  input  logic              in_sof_i,
  input  logic              in_fid_i,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_data_o,
  output logic              out_sol_o,
  output logic              out_interp_o
);
  localparam int unsigned XW = $clog2(LINE_W);
  localparam int unsigned YW = $clog2(NUM_LINES + 2);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_W - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(NUM_LINES - 1);
  localparam logic [YW-1:0] Y_TWO  = YW'(2);
  localparam logic [YW-1:0] Y_ONE  = YW'(1);

  st_e                         st_q;
  logic [XW-1:0]               in_x_q, em_x_q, wx;
  logic [YW-1:0]               in_y_q, wy, ek_q, et_q;
  logic                        pass_q, acc, line_done, byp_act;
  logic [TAPS-1:0][COEF_W-1:0] coef;
  logic [TAPS-1:0][SLOT_W-1:0] rslot;
  logic [TAPS-1:0][PIX_W-1:0]  rpix;
  logic [PIX_W-1:0]            fir_pix;

  assign in_ready_o = (st_q == ST_IN);
  assign acc        = in_valid_i & in_ready_o;
  assign wx         = in_sof_i ? '0 : in_x_q;
  assign wy         = in_sof_i ? '0 : in_y_q;
  assign line_done  = acc && (wx == X_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IN;
      in_x_q <= '0;
      in_y_q <= '0;
      em_x_q <= '0;
      ek_q   <= '0;
      et_q   <= '0;
      pass_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IN: if (acc) begin
          if (line_done) begin
            in_x_q <= '0;
            in_y_q <= (wy == Y_LAST) ? '0 : wy + Y_ONE;
            if (wy >= Y_TWO) begin
              st_q   <= ST_EMIT;
              em_x_q <= '0;
              pass_q <= 1'b0;
              ek_q   <= wy - Y_TWO;
              et_q   <= (wy == Y_LAST) ? Y_LAST : wy - Y_TWO;
            end
          end else begin
            in_x_q <= wx + XW'(1);
            in_y_q <= wy;
          end
        end
        ST_EMIT: begin
          if (em_x_q == X_LAST) begin
            em_x_q <= '0;
            if (!byp_act && !pass_q) begin
              pass_q <= 1'b1;
            end else begin
              pass_q <= 1'b0;
              if (ek_q == et_q) st_q <= ST_IN;
              else              ek_q <= ek_q + Y_ONE;
            end
          end else begin
            em_x_q <= em_x_q + XW'(1);
          end
        end
        default: st_q <= ST_IN;
      endcase
    end
  end

  // neighbour lines k-1..k+2, clamped to the picture
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [YW-1:0] ln;
    always_comb begin
      if (t == 0) begin
        ln = (ek_q == '0) ? '0 : ek_q - Y_ONE;
      end else begin
        ln = ek_q + YW'(t - 1);
        if (ln > Y_LAST) ln = Y_LAST;
      end
    end
    assign rslot[t] = ln[SLOT_W-1:0];
  end

  chroma_vup_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .load_i  (acc & in_sof_i),
    .fid_i   (in_fid_i),
    .pass_i  (pass_q),
    .coef_o  (coef),
    .byp_o   (byp_act)
  );

  chroma_vup_lbuf #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_lbuf (
    .clk_i   (clk_i),
    .we_i    (acc),
    .wslot_i (wy[SLOT_W-1:0]),
    .wx_i    (wx),
    .wdata_i (in_data_i),
    .rslot_i (rslot),
    .rx_i    (em_x_q),
    .rdata_o (rpix)
  );

  chroma_vup_fir #(.PIX_W(PIX_W)) u_fir (
    .coef_i (coef),
    .pix_i  (rpix),
    .pix_o  (fir_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_data_o   <= '0;
      out_sol_o    <= 1'b0;
      out_interp_o <= 1'b0;
    end else begin
      out_valid_o <= (st_q == ST_EMIT);
      if (st_q == ST_EMIT) begin
        out_data_o   <= byp_act ? rpix[1] : fir_pix;
        out_sol_o    <= (em_x_q == '0);
        out_interp_o <= pass_q;
      end
    end
  end
endmodule

// File: rtl/chroma_vup_chk.sv
module chroma_vup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic out_sol_o,
  input logic out_interp_o,
  input logic byp_i
);
  AST_NO_OUT_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !out_valid_o); // R9

  AST_LINE_START_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_sol_o); // R5

  AST_INTERP_FOLLOWS_ANCHOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $rose(out_interp_o)) |-> ($past(out_valid_o) && out_sol_o)); // R5

  AST_BYPASS_SINGLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && byp_i) |-> !out_interp_o); // R7
endmodule

bind chroma_vup chroma_vup_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_sol_o    (out_sol_o),
  .out_interp_o (out_interp_o),
  .byp_i        (byp_act)
);

// File: tb/sim_chroma_vup.sv
`timescale 1ns/1ps
module sim_chroma_vup;
  localparam int W = 8;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_fid = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sol;
  logic        out_interp;

  int errs = 0;
  int checks = 0;
  logic [31:0] shd [8];
  logic [31:0] act [8];
  int pix [N][W];
  int got [$];
  int expq [$];
  int acc_cnt, first_acc, r9_bad;

  always #10 clk = ~clk;

  chroma_vup #(.PIX_W(8), .LINE_W(W), .NUM_LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sof_i(in_sof), .in_fid_i(in_fid),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sol_o(out_sol),
    .out_interp_o(out_interp));

  task automatic chk(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  function automatic logic [31:0] mkw(input int a, input int m, input int b);
    return {a[13:0], m[1:0], b[13:0], 2'b00};
  endfunction

  function automatic int coef(input int s, input int t);
    logic [31:0] w;
    int raw;
    w = act[2*s + t/2];
    raw = (t % 2 == 0) ? int'(w[31:18]) : int'(w[15:2]);
    return (raw >= 8192) ? raw - 16384 : raw;
  endfunction

  function automatic int fexp(input int k, input int x, input int s);
    int sum, l, r;
    sum = 0;
    for (int t = 0; t < 4; t++) begin
      l = k + t - 1;
      if (l < 0) l = 0;
      if (l > N-1) l = N-1;
      sum += coef(s, t) * pix[l][x];
    end
    r = (sum + 512) >>> 10;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (got.size() == 0 && first_acc < 0) first_acc = acc_cnt;
        got.push_back(int'(out_data) | (int'(out_sol) << 8) | (int'(out_interp) << 9));
        if (in_ready && out_sol) r9_bad++;
      end
      if (in_valid && in_ready) acc_cnt++;
    end
  end

  task automatic wcfg(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    shd[a] = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input int d, input bit sof);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'(d); in_sof = sof;
    while (!in_ready) begin @(posedge clk); #1; end
  endtask

  task automatic make_pix(input int pat);
    for (int y = 0; y < N; y++)
      for (int x = 0; x < W; x++)
        case (pat)
          0: pix[y][x] = (y*37 + x*11) % 256;
          1: pix[y][x] = (x*x*13 + y*97 + 5 + ((x*y) % 7)*29) % 256;
          default: pix[y][x] = ((y + x/4) % 2) ? 255 : 0;
        endcase
  endtask

  task automatic run_frame(input int pat, input bit fid, input bit mid_wr,
                           input int mid_a, input logic [31:0] mid_d, input string req);
    bit byp;
    make_pix(pat);
    for (int i = 0; i < 8; i++) act[i] = shd[i];
    byp = (act[0][17:16] == 2'd1);
    expq.delete(); got.delete();
    acc_cnt = 0; first_acc = -1; r9_bad = 0;
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < (byp ? 1 : 2); p++)
        for (int x = 0; x < W; x++)
          expq.push_back((byp ? pix[k][x] : fexp(k, x, 2*int'(fid) + p))
                         | ((x == 0) << 8) | (p << 9));
    end
    for (int y = 0; y < N; y++) begin
      for (int x = 0; x < W; x++) begin
        in_fid = fid;
        send(pix[y][x], (y == 0 && x == 0));
      end
      if (mid_wr && y == 0) begin
        @(posedge clk); #1; in_valid = 1'b0;
        wcfg(mid_a, mid_d);
      end
    end
    @(posedge clk); #1; in_valid = 1'b0; in_sof = 1'b0;
    repeat (8*W + 10) @(posedge clk);
    chk(got.size() == expq.size(), {req, " sample count"}, got.size(), expq.size());
    chk(first_acc == 3*W, "R5 first output after three lines", first_acc, 3*W);
    chk(r9_bad == 0, "R9 ready low during emission", r9_bad, 0);
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] == expq[i], req, got[i], expq[i]);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shd[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2 R3 R4: progressive sets, both fields equal
    for (int f = 0; f < 2; f++) begin
      wcfg(4*f+0, mkw(14'h00C8, 0, 14'h0348));
      wcfg(4*f+1, mkw(14'h0018, 0, 14'h3FD8));
      wcfg(4*f+2, mkw(14'h3FB8, 0, 14'h0378));
      wcfg(4*f+3, mkw(14'h00E8, 0, 14'h3FE8));
    end
    run_frame(0, 1'b0, 1'b0, 0, '0, "R3 R4 ramp progressive");

    // R6: distinct sets per field
    wcfg(0, mkw(14'h0051, 0, 14'h03D5));
    wcfg(1, mkw(14'h3FE3, 0, 14'h3FF7));
    wcfg(2, mkw(14'h3FB5, 0, 14'h02E9));
    wcfg(3, mkw(14'h018F, 0, 14'h3FD3));
    wcfg(4, mkw(14'h016B, 0, 14'h0247));
    wcfg(5, mkw(14'h00B1, 0, 14'h3F9D));
    wcfg(6, mkw(14'h3FCF, 0, 14'h03DB));
    wcfg(7, mkw(14'h005D, 0, 14'h3FF9));
    run_frame(1, 1'b1, 1'b0, 0, '0, "R6 field 1 sets");
    run_frame(1, 1'b0, 1'b0, 0, '0, "R6 field 0 sets");

    // R3 clamp: gain 3 on anchor, -2/+1 on interp
    wcfg(0, mkw(14'h0000, 0, 14'h0C00));
    wcfg(1, mkw(14'h0000, 0, 14'h0000));
    wcfg(2, mkw(14'h0000, 0, 14'h3800));
    wcfg(3, mkw(14'h0400, 0, 14'h0000));
    run_frame(2, 1'b0, 1'b0, 0, '0, "R3 clamp limits");

    // R7 R8: bypass frame with mid-frame switch to filter
    wcfg(0, mkw(14'h1234, 1, 14'h2345));
    run_frame(0, 1'b0, 1'b1, 0, mkw(14'h0000, 0, 14'h0200), "R7 R8 bypass frame");
    wcfg(2, mkw(14'h0000, 0, 14'h3E00));
    wcfg(3, mkw(14'h0400, 0, 14'h0000));
    run_frame(1, 1'b0, 1'b0, 0, '0, "R8 new setting next frame");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule